// File: doc/BRIEF.md
# Management Response Header and Doorbell Sequencer

This block sits on the controller side of a shared-memory management channel. Each time a request has been processed, the block receives the decoded request header fields and the length and status of the response. It builds the 64-bit acknowledgement header and the first payload word. It then holds them until the queue writer reports that they are stored. The controller can also push an unsolicited event through the same path, and the block forms a notification header from the fields the controller supplies.

The requester chooses per message whether it wants to be signalled. Bit 3 of the request flags asks for a doorbell, and without it the requester is assumed to poll. A doorbell goes out only once the acknowledgement has been written. If a message-signalled interrupt has been configured successfully, the doorbell is one write of the configured data word to the configured address over a valid/ready handshake. Otherwise it is a one-cycle pulse on an edge-interrupt output. The block holds the MSI address, data and enable state itself.

Top module: `mgmt_ack_bell`

## Requirements
- R1: An acknowledgement header carries the request's token in bits 63:48, its service group in bits 15:0 and its service in bits 23:16, all unchanged. Flags bits 31:24 hold the message type 2 (acknowledgement) in bits 26:24 and zero elsewhere.
- R2: The data length in bits 47:32 is the payload the message actually carries. For an acknowledgement this is the response length plus 4 bytes for the status word. For a notification it is the response length itself.
- R3: The first payload word of an acknowledgement equals the status input: 0 for success, any nonzero code passed through unchanged. For a notification that word is 0.
- R4: A doorbell is raised for a message when bit 3 of its request flags is 1, and no doorbell of either kind is raised when that bit is 0, whatever the other flag bits hold.
- R5: No doorbell appears while the header is waiting to be written. In wired mode, the edge-interrupt output is high for exactly the one cycle after the cycle in which the written strobe is seen.
- R6: A notification header carries service 0 whatever the service input holds, message type 3 in bits 26:24, and the token, service group and length supplied with it.
- R7: In MSI mode the doorbell presents the configured address and data with valid held high and both values stable until ready is seen.
- R8: MSI mode becomes active only after a configuration write whose address is 4-byte aligned with the enable input set, and only when MSI support is built in. A misaligned configuration write, or one with enable clear, leaves wired mode in effect.
- R9: Request-ready is high only when the block is idle. It drops from the accepted request until the header is written and any MSI write has been accepted.
- R10: After reset the block is ready, with no header valid, no interrupt pulse, no MSI write pending and MSI mode inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A processed request or a notification is offered |
| req_ready | output | 1 | Block idle and able to take a message |
| req_notify | input | 1 | 1: build a notification, 0: build an acknowledgement |
| req_token | input | 16 | Request token |
| req_group | input | 16 | Service group ID |
| req_service | input | 8 | Service ID |
| req_flags | input | 8 | Request flags; bit 3 asks for a doorbell |
| rsp_len | input | 16 | Response payload bytes beyond the status word |
| rsp_status | input | STATUS_W | Completion status, 0 = success |
| hdr_valid | output | 1 | Header and first word are ready to store |
| hdr_data | output | 64 | Formed message header |
| hdr_word0 | output | STATUS_W | First payload word |
| hdr_written | input | 1 | Strobe: header has been stored in the queue |
| irq_edge | output | 1 | One-cycle wired doorbell pulse |
| msi_valid | output | 1 | MSI write pending |
| msi_ready | input | 1 | MSI write accepted |
| msi_addr | output | ADDR_W | MSI target address |
| msi_data | output | DATA_W | MSI data word |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | MSI address to configure |
| cfg_data | input | DATA_W | MSI data to configure |
| cfg_enable | input | 1 | Enable MSI delivery with this configuration |
| msi_active | output | 1 | MSI delivery in effect |

## Verification
The properties watch on every cycle the invariants that span cycles. The latched token must reappear in the header one cycle after acceptance, and notifications must always show service 0. The interrupt pulse must last one cycle and must follow a written strobe. An MSI write must stay stable while it stalls, no request may be accepted during it, and MSI mode must only switch on after an aligned configuration write. The bench scenarios are needed for the field mapping of each header, the length arithmetic, and the status pass-through. They also cover the choice between no doorbell, a pulse and an MSI write across flag patterns, and the mode changes driven by good, misaligned and disabled configurations.

// File: rtl/mab_pkg.sv
package mab_pkg;
   localparam int HDR_W   = 64;
   localparam int TOKEN_W = 16;
   localparam int GROUP_W = 16;
   localparam int SVC_W   = 8;
   localparam int FLAG_W  = 8;
   localparam int LEN_W   = 16;

   typedef enum logic [2:0] {
      MT_REQ    = 3'd0,
      MT_POSTED = 3'd1,
      MT_ACK    = 3'd2,
      MT_NOTIFY = 3'd3
   } msg_kind_e;

   typedef struct packed {
      logic [TOKEN_W-1:0] token;
      logic [LEN_W-1:0]   dlen;
      logic [FLAG_W-1:0]  flags;
      logic [SVC_W-1:0]   svc;
      logic [GROUP_W-1:0] group;
   } hdr_t;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_WRITE = 2'd1,
      SQ_MSI   = 2'd2
   } seq_e;
endpackage

// File: rtl/mab_hdr_fmt.sv
module mab_hdr_fmt
   import mab_pkg::*;
#(
   parameter int STATUS_W = 32
) (
   input  logic                notify,
   input  logic [TOKEN_W-1:0]  token,
   input  logic [GROUP_W-1:0]  group,
   input  logic [SVC_W-1:0]    svc,
   input  logic [LEN_W-1:0]    plen,
   input  logic [STATUS_W-1:0] status,
   output hdr_t                hdr,
   output logic [STATUS_W-1:0] word0
);
   localparam int STATUS_BYTES = STATUS_W / 8;

   if (STATUS_W % 8 != 0 || STATUS_W < 8) begin : g_bad_status
      $error("STATUS_W must be a positive whole number of bytes");
   end

   always_comb begin
      hdr.token = token;
      hdr.group = group;
      if (notify) begin
         hdr.svc   = '0;
         hdr.flags = {{(FLAG_W-3){1'b0}}, MT_NOTIFY};
         hdr.dlen  = plen;
         word0     = '0;
      end else begin
         hdr.svc   = svc;
         hdr.flags = {{(FLAG_W-3){1'b0}}, MT_ACK};
         hdr.dlen  = plen + LEN_W'(STATUS_BYTES);
         word0     = status;
      end
   end
endmodule

// File: rtl/mab_msi_cfg.sv
module mab_msi_cfg #(
   parameter int ADDR_W      = 64,
   parameter int DATA_W      = 32,
   parameter bit MSI_SUPPORT = 1'b1,
   parameter int ALIGN_BITS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              cfg_enable,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [DATA_W-1:0] tgt_data,
   output logic              active
);
   if (ALIGN_BITS < 0 || ALIGN_BITS >= ADDR_W) begin : g_bad_align
      $error("ALIGN_BITS out of range");
   end

   if (MSI_SUPPORT) begin : g_msi
      logic aligned;
      assign aligned = (cfg_addr[ALIGN_BITS-1:0] == '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tgt_addr <= '0;
            tgt_data <= '0;
            active   <= 1'b0;
         end else if (cfg_wr) begin
            if (aligned) begin
               tgt_addr <= cfg_addr;
               tgt_data <= cfg_data;
            end
            active <= aligned && cfg_enable;
         end
      end

      // R8
      msi_on_after_good_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(active) |-> $past(cfg_wr) && $past(cfg_enable)
                           && ($past(cfg_addr[ALIGN_BITS-1:0]) == '0));
   end else begin : g_no_msi
      logic unused_cfg;
      assign unused_cfg = ^{clk, rst_n, cfg_wr, cfg_addr, cfg_data, cfg_enable};
      assign tgt_addr = '0;
      assign tgt_data = '0;
      assign active   = 1'b0;
   end
endmodule

// File: rtl/mab_bell_seq.sv
module mab_bell_seq
   import mab_pkg::*;
#(
   parameter int STATUS_W = 32,
   parameter int ADDR_W   = 64,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  hdr_t                hdr_in,
   input  logic [STATUS_W-1:0] word0_in,
   input  logic                bell_in,
   output logic                out_valid,
   output hdr_t                hdr_out,
   output logic [STATUS_W-1:0] word0_out,
   input  logic                written,
   input  logic                msi_on,
   input  logic [ADDR_W-1:0]   tgt_addr,
   input  logic [DATA_W-1:0]   tgt_data,
   output logic                pulse,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data
);
   seq_e st;
   logic bell_q;
   logic take;

   assign in_ready  = (st == SQ_IDLE);
   assign out_valid = (st == SQ_WRITE);
   assign wr_valid  = (st == SQ_MSI);
   assign take      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         hdr_out   <= '0;
         word0_out <= '0;
         bell_q    <= 1'b0;
         pulse     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         pulse <= 1'b0;
         unique case (st)
            SQ_IDLE: if (take) begin
               hdr_out   <= hdr_in;
               word0_out <= word0_in;
               bell_q    <= bell_in;
               st        <= SQ_WRITE;
            end
            SQ_WRITE: if (written) begin
               if (bell_q && msi_on) begin
                  wr_addr <= tgt_addr;
                  wr_data <= tgt_data;
                  st      <= SQ_MSI;
               end else begin
                  pulse <= bell_q;
                  st    <= SQ_IDLE;
               end
            end
            SQ_MSI: if (wr_ready) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   // R5
   pulse_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(written) && $past(out_valid));
   // R5
   pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
   // R7
   msi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
   // R9
   stall_during_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !in_ready);
endmodule

// File: rtl/mgmt_ack_bell.sv
module mgmt_ack_bell
   import mab_pkg::*;
#(
   parameter int STATUS_W    = 32,
   parameter int ADDR_W      = 64,
   parameter int DATA_W      = 32,
   parameter bit MSI_SUPPORT = 1'b1,
   parameter int BELL_BIT    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_notify,
   input  logic [15:0]         req_token,
   input  logic [15:0]         req_group,
   input  logic [7:0]          req_service,
   input  logic [7:0]          req_flags,
   input  logic [15:0]         rsp_len,
   input  logic [STATUS_W-1:0] rsp_status,
   output logic                hdr_valid,
   output logic [63:0]         hdr_data,
   output logic [STATUS_W-1:0] hdr_word0,
   input  logic                hdr_written,
   output logic                irq_edge,
   output logic                msi_valid,
   input  logic                msi_ready,
   output logic [ADDR_W-1:0]   msi_addr,
   output logic [DATA_W-1:0]   msi_data,
   input  logic                cfg_wr,
   input  logic [ADDR_W-1:0]   cfg_addr,
   input  logic [DATA_W-1:0]   cfg_data,
   input  logic                cfg_enable,
   output logic                msi_active
);
   if (BELL_BIT < 3 || BELL_BIT >= FLAG_W) begin : g_bad_bell
      $error("BELL_BIT must lie above the message type field");
   end

   hdr_t                hdr_new, hdr_held;
   logic [STATUS_W-1:0] word0_new;
   logic [ADDR_W-1:0]   tgt_addr;
   logic [DATA_W-1:0]   tgt_data;

   mab_hdr_fmt #(.STATUS_W(STATUS_W)) u_fmt (
      .notify (req_notify),
      .token  (req_token),
      .group  (req_group),
      .svc    (req_service),
      .plen   (rsp_len),
      .status (rsp_status),
      .hdr    (hdr_new),
      .word0  (word0_new)
   );

   mab_msi_cfg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MSI_SUPPORT(MSI_SUPPORT), .ALIGN_BITS(2)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_data   (cfg_data),
      .cfg_enable (cfg_enable),
      .tgt_addr   (tgt_addr),
      .tgt_data   (tgt_data),
      .active     (msi_active)
   );

   mab_bell_seq #(.STATUS_W(STATUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ready  (req_ready),
      .hdr_in    (hdr_new),
      .word0_in  (word0_new),
      .bell_in   (req_flags[BELL_BIT]),
      .out_valid (hdr_valid),
      .hdr_out   (hdr_held),
      .word0_out (hdr_word0),
      .written   (hdr_written),
      .msi_on    (msi_active),
      .tgt_addr  (tgt_addr),
      .tgt_data  (tgt_data),
      .pulse     (irq_edge),
      .wr_valid  (msi_valid),
      .wr_ready  (msi_ready),
      .wr_addr   (msi_addr),
      .wr_data   (msi_data)
   );

   assign hdr_data = hdr_held;

   // R1
   token_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> hdr_valid && hdr_data[63:48] == $past(req_token)
                                 && hdr_data[15:0] == $past(req_group));
   // R6
   notify_svc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_data[26:24] == 3'd3 |-> hdr_data[23:16] == '0);
   // R4
   no_bell_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_flags[BELL_BIT] |=> !irq_edge && !msi_valid);
endmodule

// File: tb/mgmt_ack_bell_test.sv
`timescale 1ns/1ps
module mgmt_ack_bell_test;
   localparam int NV = 6;
   // fields: notify, flags, group, service, token, len, status
   localparam logic [96:0] VECS [NV] = '{
      {1'b0, 8'h08, 16'h0003, 8'h05, 16'h1234, 16'd8,   32'h0000_0000},
      {1'b0, 8'h00, 16'h8001, 8'h0A, 16'hFFFF, 16'd0,   32'hFFFF_FFFE},
      {1'b0, 8'hF7, 16'h7C00, 8'hFF, 16'h0000, 16'd100, 32'h0000_0005},
      {1'b1, 8'h08, 16'h0004, 8'h07, 16'h0042, 16'd12,  32'h0000_DEAD},
      {1'b1, 8'h00, 16'hFFFF, 8'h01, 16'h0043, 16'd0,   32'h0000_0000},
      {1'b0, 8'h0F, 16'h0001, 8'h02, 16'h1235, 16'd4,   32'h0000_0001}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_notify = 0, hdr_written = 0, msi_ready = 0;
   logic cfg_wr = 0, cfg_enable = 0;
   logic [15:0] req_token = 0, req_group = 0, rsp_len = 0;
   logic [7:0] req_service = 0, req_flags = 0;
   logic [31:0] rsp_status = 0, cfg_data = 0;
   logic [63:0] cfg_addr = 0;
   logic req_ready, hdr_valid, irq_edge, msi_valid, msi_active;
   logic [63:0] hdr_data, msi_addr;
   logic [31:0] hdr_word0, msi_data;
   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   mgmt_ack_bell uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_notify(req_notify), .req_token(req_token), .req_group(req_group),
      .req_service(req_service), .req_flags(req_flags), .rsp_len(rsp_len),
      .rsp_status(rsp_status), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
      .hdr_word0(hdr_word0), .hdr_written(hdr_written), .irq_edge(irq_edge),
      .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
      .msi_data(msi_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_data(cfg_data), .cfg_enable(cfg_enable), .msi_active(msi_active)
   );

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic configure(input logic [63:0] a, input logic [31:0] d, input logic en);
      @(negedge clk);
      cfg_wr = 1; cfg_addr = a; cfg_data = d; cfg_enable = en;
      @(negedge clk);
      cfg_wr = 0;
   endtask

   // one message: checks header, then the doorbell outcome
   task automatic run_msg(input logic [96:0] v, input logic msi_mode,
                          input logic [63:0] ea, input logic [31:0] ed);
      logic nt; logic [7:0] fl, sv, efl, esv; logic [15:0] gr, tk, ln, eln;
      logic [31:0] stt, ew0; logic bell;
      {nt, fl, gr, sv, tk, ln, stt} = v;
      bell = fl[3];
      esv  = nt ? 8'h00 : sv;
      efl  = nt ? 8'h03 : 8'h02;
      eln  = nt ? ln : ln + 16'd4;
      ew0  = nt ? 32'h0 : stt;
      @(negedge clk);
      req_valid = 1; req_notify = nt; req_flags = fl; req_group = gr;
      req_service = sv; req_token = tk; rsp_len = ln; rsp_status = stt;
      @(negedge clk);
      req_valid = 0;
      chk(hdr_valid, 1, "R1 header valid");
      chk(hdr_data[63:48], tk, "R1 token");
      chk(hdr_data[15:0], gr, "R1 group");
      chk(hdr_data[23:16], esv, nt ? "R6 notify service" : "R1 service");
      chk(hdr_data[31:24], efl, nt ? "R6 notify type" : "R1 ack type");
      chk(hdr_data[47:32], eln, "R2 data length");
      chk(hdr_word0, ew0, "R3 status word");
      chk(req_ready, 0, "R9 busy while header pending");
      @(negedge clk);
      chk({irq_edge, msi_valid}, 0, "R5 no doorbell before written");
      hdr_written = 1;
      @(negedge clk);
      hdr_written = 0;
      chk(irq_edge, bell && !msi_mode, "R4 R5 wired pulse");
      chk(msi_valid, bell && msi_mode, "R4 R7 msi write");
      if (bell && msi_mode) begin
         chk(msi_addr, ea, "R7 msi address");
         chk(msi_data, ed, "R7 msi data");
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(msi_valid, 1, "R7 msi held");
            chk(req_ready, 0, "R9 stalled by msi");
         end
         msi_ready = 1;
         @(negedge clk);
         msi_ready = 0;
         chk(msi_valid, 0, "R7 msi done");
      end
      @(negedge clk);
      chk(irq_edge, 0, "R5 pulse one cycle");
      chk(req_ready, 1, "R9 ready again");
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10
      chk({req_ready, hdr_valid, irq_edge, msi_valid, msi_active}, 5'b10000, "R10 reset state");
      for (int k = 0; k < NV; k++) run_msg(VECS[k], 1'b0, 64'h0, 32'h0);
      // R8 misaligned address keeps wired mode
      configure(64'h0000_0000_2800_1002, 32'h0000_0077, 1'b1);
      chk(msi_active, 0, "R8 misaligned rejected");
      run_msg(VECS[0], 1'b0, 64'h0, 32'h0);
      // R8 good configuration
      configure(64'h0000_0001_2800_1000, 32'h0000_0055, 1'b1);
      chk(msi_active, 1, "R8 msi enabled");
      run_msg(VECS[0], 1'b1, 64'h0000_0001_2800_1000, 32'h0000_0055);
      run_msg(VECS[3], 1'b1, 64'h0000_0001_2800_1000, 32'h0000_0055);
      run_msg(VECS[1], 1'b1, 64'h0, 32'h0);
      run_msg(VECS[2], 1'b1, 64'h0, 32'h0);
      // R8 enable clear returns to wired mode
      configure(64'h0000_0000_0000_0040, 32'h0000_0099, 1'b0);
      chk(msi_active, 0, "R8 msi disabled");
      run_msg(VECS[5], 1'b0, 64'h0, 32'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule